// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets software running on one hart interrupt another hart in a four-hart system. Software does this through a 32-bit register bus. A shared pending word holds one byte per source hart. Inside each byte, the target hart is picked by a bit counted downward from bit 7. Setting a bit requests an interrupt. Each hart has its own enable word and its own claim/complete register, and drives one interrupt output line.

A hart whose line is high reads its claim register. The read returns the source ID, which is the bit index in the pending word. The same read clears that pending bit and marks the ID as in service. Once the hart has handled the interrupt, it writes the same ID back to its claim register to complete it. While an ID is in service, it is hidden from every hart, even if software sets its pending bit again.

Top module: `ipi_ctrl_top`

## Requirements
- R1: After reset, the pending word, every enable word and every in-service set are zero, all interrupt outputs are low, and the read response flag is low.
- R2: A write to the pending word at address 0x1000 ORs the written value into the pending bits. The bit that signals from source hart s to target hart t is 8*s + 7 - t. Bit 0 is reserved and never sets. Writing a 0 bit leaves that pending bit as it is, so only a claim can clear a pending bit.
- R3: Every read request gets its data and a high `bus_rvalid` one cycle later, and only read requests do. Reading address 0x1000 returns the current pending word.
- R4: The enable word of hart h sits at address 0x2000 + h*0x80. A write replaces the word, and a read returns it.
- R5: `irq_o[h]` is high exactly when at least one nonzero bit is pending, enabled in hart h's enable word, and not in service for any hart.
- R6: The claim register of hart h sits at address 0x200004 + h*0x1000. Reading it returns the lowest nonzero ID that is eligible for hart h. The read also clears that pending bit and records the ID as in service for hart h.
- R7: A claim read when hart h has no eligible ID returns 0 and changes no state.
- R8: An ID that is in service for any hart is withheld from all harts, even when its pending bit is set again. It becomes eligible once its owner completes it.
- R9: Writing an ID n to hart h's claim register completes n only if n is nonzero, the upper bits of the written word are zero, and n is in service for hart h. Any other write to a claim register is ignored.
- R10: A read of an unmapped address returns 0, and a write to an unmapped address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A register access is requested this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data is valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| irq_o | output | 4 | Interrupt line for each hart |

## Verification
The assertions check these properties on every cycle:
- The read response timing.
- Pending bit 0 staying clear.
- Pending bits falling only on a claim.
- A claimed ID landing in service with its pending bit cleared.
- No ID being owned by two harts at once.
- Non-claiming reads leaving pending and in-service state untouched.

Only the directed scenarios can show the values. These include which ID a claim returns when several are pending, the masking of interrupt lines by the enable words, the hiding of a re-pended ID while it is in service, and the rejection of completions from the wrong hart, of ID 0, and of words with upper bits set.

// File: rtl/ipi_ctrl_pkg.sv
package ipi_ctrl_pkg;

  localparam int unsigned PEND_OFS   = 32'h0000_1000;
  localparam int unsigned EN_BASE    = 32'h0000_2000;
  localparam int unsigned EN_STRIDE  = 32'h0000_0080;
  localparam int unsigned CLM_BASE   = 32'h0020_0004;
  localparam int unsigned CLM_STRIDE = 32'h0000_1000;

  // Byte address of hart h's enable word
  function automatic int unsigned enable_addr(input int unsigned h);
    return EN_BASE + h * EN_STRIDE;
  endfunction

  // Byte address of hart h's claim/complete register
  function automatic int unsigned claim_addr(input int unsigned h);
    return CLM_BASE + h * CLM_STRIDE;
  endfunction

endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec
  import ipi_ctrl_pkg::*;
#(
  parameter int N_HARTS = 4,
  parameter int ADDR_W  = 22
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               hit_pend_o,
  output logic [N_HARTS-1:0] hit_en_o,
  output logic [N_HARTS-1:0] hit_clm_o
);

  assign hit_pend_o = (addr_i == ADDR_W'(PEND_OFS));

  for (genvar h = 0; h < N_HARTS; h++) begin : g_hart
    assign hit_en_o[h]  = (addr_i == ADDR_W'(enable_addr(h)));
    assign hit_clm_o[h] = (addr_i == ADDR_W'(claim_addr(h)));
  end

endmodule

// File: rtl/ipi_claim_pick.sv
module ipi_claim_pick #(
  parameter  int PEND_W = 32,
  localparam int ID_W   = $clog2(PEND_W)
) (
  input  logic [PEND_W-1:0] cand_i,
  output logic [ID_W-1:0]   id_o,
  output logic              any_o
);

  // Lowest nonzero index wins; index 0 is never a valid ID
  always_comb begin
    id_o = '0;
    for (int i = PEND_W - 1; i >= 1; i--) begin
      if (cand_i[i]) id_o = ID_W'(i);
    end
  end

  assign any_o = (id_o != '0);

endmodule

// File: rtl/ipi_hart_slot.sv
module ipi_hart_slot #(
  parameter  int PEND_W = 32,
  parameter  int DATA_W = 32,
  localparam int ID_W   = $clog2(PEND_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we_i,
  input  logic              claim_rd_i,
  input  logic              done_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PEND_W-1:0] pend_i,
  input  logic [PEND_W-1:0] svc_all_i,
  output logic [PEND_W-1:0] en_o,
  output logic [PEND_W-1:0] svc_o,
  output logic [ID_W-1:0]   id_o,
  output logic              any_o,
  output logic              claim_fire_o
);

  logic [PEND_W-1:0] en_q, svc_q, cand;
  logic [ID_W-1:0]   done_id;
  logic              done_ok;

  always_comb begin
    cand    = pend_i & en_q & ~svc_all_i;
    cand[0] = 1'b0;
  end

  ipi_claim_pick #(.PEND_W(PEND_W)) pick_i (
    .cand_i (cand),
    .id_o   (id_o),
    .any_o  (any_o)
  );

  assign claim_fire_o = claim_rd_i & any_o;
  assign done_id      = wdata_i[ID_W-1:0];
  assign done_ok      = done_wr_i && (wdata_i[DATA_W-1:ID_W] == '0)
                        && (done_id != '0) && svc_q[done_id];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      svc_q <= '0;
    end else begin
      if (en_we_i)      en_q          <= wdata_i[PEND_W-1:0];
      if (claim_fire_o) svc_q[id_o]   <= 1'b1;
      if (done_ok)      svc_q[done_id] <= 1'b0;
    end
  end

  assign en_o  = en_q;
  assign svc_o = svc_q;

endmodule

// File: rtl/ipi_ctrl_top.sv
module ipi_ctrl_top #(
  parameter int N_HARTS = 4,
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               bus_rvalid,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [N_HARTS-1:0] irq_o
);

  localparam int PEND_W = 8 * N_HARTS;
  localparam int ID_W   = $clog2(PEND_W);

  logic                      wr_req, rd_req;
  logic                      hit_pend;
  logic [N_HARTS-1:0]        hit_en, hit_clm;
  logic [PEND_W-1:0]         pend_q, pend_set, claim_clr, svc_all;
  logic [PEND_W-1:0]         en_arr  [N_HARTS];
  logic [PEND_W-1:0]         svc_arr [N_HARTS];
  logic [ID_W-1:0]           id_arr  [N_HARTS];
  logic [N_HARTS-1:0]        any_vec, claim_fire;
  logic [N_HARTS*PEND_W-1:0] svc_flat;
  logic                      claim_take;
  logic [ID_W-1:0]           claim_id;
  logic [DATA_W-1:0]         rd_mux;

  assign wr_req = bus_valid & bus_write;
  assign rd_req = bus_valid & ~bus_write;

  ipi_addr_dec #(.N_HARTS(N_HARTS), .ADDR_W(ADDR_W)) dec_i (
    .addr_i     (bus_addr),
    .hit_pend_o (hit_pend),
    .hit_en_o   (hit_en),
    .hit_clm_o  (hit_clm)
  );

  for (genvar h = 0; h < N_HARTS; h++) begin : g_slot
    ipi_hart_slot #(.PEND_W(PEND_W), .DATA_W(DATA_W)) slot_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_we_i      (wr_req & hit_en[h]),
      .claim_rd_i   (rd_req & hit_clm[h]),
      .done_wr_i    (wr_req & hit_clm[h]),
      .wdata_i      (bus_wdata),
      .pend_i       (pend_q),
      .svc_all_i    (svc_all),
      .en_o         (en_arr[h]),
      .svc_o        (svc_arr[h]),
      .id_o         (id_arr[h]),
      .any_o        (any_vec[h]),
      .claim_fire_o (claim_fire[h])
    );
    assign svc_flat[h*PEND_W +: PEND_W] = svc_arr[h];
  end

  assign irq_o      = any_vec;
  assign claim_take = |claim_fire;

  always_comb begin
    svc_all   = '0;
    claim_clr = '0;
    claim_id  = '0;
    for (int h = 0; h < N_HARTS; h++) begin
      svc_all = svc_all | svc_arr[h];
      if (claim_fire[h]) begin
        claim_clr[id_arr[h]] = 1'b1;
        claim_id             = id_arr[h];
      end
    end
  end

  always_comb begin
    pend_set    = (wr_req && hit_pend) ? bus_wdata[PEND_W-1:0] : '0;
    pend_set[0] = 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_pend) rd_mux = DATA_W'(pend_q);
    for (int h = 0; h < N_HARTS; h++) begin
      if (hit_en[h])  rd_mux = DATA_W'(en_arr[h]);
      if (hit_clm[h]) rd_mux = DATA_W'(id_arr[h]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      pend_q     <= (pend_q | pend_set) & ~claim_clr;
      bus_rvalid <= rd_req;
      bus_rdata  <= rd_req ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/ipi_ctrl_sva.sv
module ipi_ctrl_sva #(
  parameter  int N_HARTS = 4,
  parameter  int PEND_W  = 32,
  localparam int ID_W    = $clog2(PEND_W)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_valid,
  input logic                      bus_write,
  input logic                      bus_rvalid,
  input logic [PEND_W-1:0]         pend_q,
  input logic [N_HARTS*PEND_W-1:0] svc_flat,
  input logic                      claim_take,
  input logic [ID_W-1:0]           claim_id
);

  logic [PEND_W-1:0] svc_or, svc_dup;

  always_comb begin
    svc_or  = '0;
    svc_dup = '0;
    for (int h = 0; h < N_HARTS; h++) begin
      svc_dup = svc_dup | (svc_or & svc_flat[h*PEND_W +: PEND_W]);
      svc_or  = svc_or | svc_flat[h*PEND_W +: PEND_W];
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);                                       // R3
  AST_NO_RSP_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);                                     // R3
  AST_RESERVED_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0]);                                                                     // R2
  AST_PEND_CLEARS_ONLY_BY_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !claim_take |=> ((pend_q & $past(pend_q)) == $past(pend_q)));                    // R2
  AST_CLAIM_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    claim_take |=> (svc_or[$past(claim_id)] && !pend_q[$past(claim_id)]));           // R6
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    svc_dup == '0);                                                                  // R8
  AST_IDLE_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!claim_take && !(bus_valid && bus_write)) |=> ($stable(pend_q) && $stable(svc_flat))); // R7

endmodule

bind ipi_ctrl_top ipi_ctrl_sva #(.N_HARTS(N_HARTS), .PEND_W(PEND_W)) sva_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_rvalid (bus_rvalid),
  .pend_q     (pend_q),
  .svc_flat   (svc_flat),
  .claim_take (claim_take),
  .claim_id   (claim_id)
);

// File: tb/ipi_ctrl_top_tb_top.sv
module ipi_ctrl_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [21:0] A_PEND = 22'h001000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [21:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;

  int checks = 0;
  int errors = 0;
  logic last_rv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ipi_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [21:0] en_a(input int h);
    return 22'(32'h2000 + h * 32'h80);
  endfunction
  function automatic logic [21:0] clm_a(input int h);
    return 22'(32'h200004 + h * 32'h1000);
  endfunction
  // Pending bit for source s to target t, as a one-hot word
  function automatic logic [31:0] ipi(input int s, input int t);
    return 32'h1 << (8 * s + 7 - t);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    last_rv = bus_rvalid;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq after reset", 32'(irq_o), 32'h0);
    chk("R1 rvalid after reset", 32'(bus_rvalid), 32'h0);
    rd(A_PEND, d);
    chk("R1 pending after reset", d, 32'h0);
    chk("R3 rvalid on read", 32'(last_rv), 32'h1);
    rd(en_a(2), d);
    chk("R1 enable after reset", d, 32'h0);
    rd(clm_a(0), d);
    chk("R7 empty claim", d, 32'h0);
  endtask

  task automatic t_send_mask();
    logic [31:0] d;
    wr(en_a(1), 32'h8080_8080 >> 1);
    wr(A_PEND, ipi(2, 1));
    chk("R5 irq for enabled target", 32'(irq_o), 32'h2);
    rd(A_PEND, d);
    chk("R3 pending readback", d, 32'h0040_0000);
    wr(A_PEND, ipi(0, 3));
    chk("R5 masked target stays low", 32'(irq_o), 32'h2);
    rd(A_PEND, d);
    chk("R2 pending OR", d, 32'h0040_0010);
    wr(A_PEND, 32'h0);
    wr(A_PEND, 32'h1);
    rd(A_PEND, d);
    chk("R2 zero and bit0 writes no effect", d, 32'h0040_0010);
  endtask

  task automatic t_claim_order();
    logic [31:0] d;
    wr(A_PEND, ipi(3, 1));
    wr(A_PEND, ipi(0, 1));
    rd(clm_a(1), d);
    chk("R6 lowest ID first", d, 32'd6);
    rd(clm_a(1), d);
    chk("R6 next ID", d, 32'd22);
    rd(A_PEND, d);
    chk("R6 claimed bits cleared", d, 32'h4000_0010);
    chk("R5 irq with one left", 32'(irq_o), 32'h2);
    rd(clm_a(1), d);
    chk("R6 last ID", d, 32'd30);
    chk("R5 irq low when none eligible", 32'(irq_o), 32'h0);
    rd(clm_a(1), d);
    chk("R7 claim with nothing eligible", d, 32'h0);
  endtask

  task automatic t_in_service();
    logic [31:0] d;
    wr(A_PEND, ipi(2, 1));
    chk("R8 re-pended in-service ID hidden", 32'(irq_o), 32'h0);
    rd(clm_a(1), d);
    chk("R8 claim skips in-service ID", d, 32'h0);
    wr(en_a(2), 32'h0040_0000);
    chk("R8 hidden from other harts", 32'(irq_o), 32'h0);
    wr(clm_a(2), 32'd22);
    chk("R9 completion by non-owner ignored", 32'(irq_o), 32'h0);
    wr(clm_a(1), 32'h0);
    wr(clm_a(1), 32'h0001_0016);
    chk("R9 zero and upper-bit completions ignored", 32'(irq_o), 32'h0);
    wr(clm_a(1), 32'd22);
    chk("R8 eligible again after completion", 32'(irq_o), 32'h6);
    rd(clm_a(2), d);
    chk("R6 other hart claims", d, 32'd22);
    chk("R5 irq after hand-over", 32'(irq_o), 32'h0);
    wr(clm_a(1), 32'd22);
    wr(A_PEND, ipi(2, 1));
    chk("R9 old owner cannot complete", 32'(irq_o), 32'h0);
    wr(clm_a(2), 32'd22);
    chk("R9 owner completes", 32'(irq_o), 32'h6);
  endtask

  task automatic t_empty_claim();
    logic [31:0] d;
    rd(clm_a(0), d);
    chk("R7 unenabled hart claim returns 0", d, 32'h0);
    rd(A_PEND, d);
    chk("R7 pending unchanged", d, 32'h0040_0010);
    chk("R7 irq unchanged", 32'(irq_o), 32'h6);
  endtask

  task automatic t_enable_unmapped();
    logic [31:0] d;
    rd(en_a(1), d);
    chk("R4 enable readback", d, 32'h4040_4040);
    wr(en_a(3), 32'h0000_FFFF);
    wr(en_a(3), 32'h0000_0010);
    rd(en_a(3), d);
    chk("R4 enable replaced", d, 32'h0000_0010);
    chk("R5 hart3 now enabled", 32'(irq_o), 32'he);
    wr(22'h001004, 32'hFFFF_FFFF);
    wr(22'h002004, 32'hFFFF_FFFF);
    rd(A_PEND, d);
    chk("R10 unmapped writes no effect", d, 32'h0040_0010);
    rd(en_a(0), d);
    chk("R10 enable untouched", d, 32'h0);
    rd(22'h001004, d);
    chk("R10 unmapped read", d, 32'h0);
    rd(22'h200000, d);
    chk("R10 unmapped read near claim", d, 32'h0);
    chk("R10 irq untouched", 32'(irq_o), 32'he);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_send_mask();
    t_claim_order();
    t_in_service();
    t_empty_claim();
    t_enable_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule